// File: doc/BRIEF.md
# Windowed Watchdog with Lockout Latch

This block supervises a processor through a periodic strobe. A millisecond tick is derived from the system clock, and the block measures the time since the last accepted strobe. A strobe is a failure if it comes too soon after the previous one. Silence for too long is also a failure. On a failure the block pulls an active-low interrupt low and raises a fail flag. The fail flag is meant to cut drive to a power amplifier.

An arm flag sets how a failure behaves. While the block is unarmed, a failure is soft: the next strobe edge clears it and restarts timing. During start-up, software can therefore strobe early, then late, then inside the window, and confirm that the watchdog reacts each time. Software arms the block by holding the arm request high during a good strobe, typically the one that opens the first normal program cycle. Once armed, any failure latches. All later strobes are then ignored until power-on reset, and power-on reset is also the only way to clear the arm flag.

The controller has five states:
- WD_BOOT: waiting for the first strobe after reset. Only the late limit applies here.
- WD_SHUT: the window is closed, and a strobe counts as early.
- WD_OPEN: the window is open, and a strobe is good.
- WD_TRIP: a soft failure while unarmed.
- WD_LOCK: a latched failure while armed.

The transitions are:
- boot_strobe: WD_BOOT to WD_SHUT.
- window_opens: WD_SHUT to WD_OPEN.
- good_strobe: WD_OPEN to WD_SHUT.
- early_strobe: WD_SHUT to a fail state.
- timeout: WD_BOOT or WD_OPEN to a fail state.
- release: WD_TRIP to WD_SHUT.
- The fail state is WD_LOCK when the block is armed and WD_TRIP otherwise.
- lock_hold: WD_LOCK stays in WD_LOCK.

Top module: `window_watchdog`

## Requirements
- R1: A strobe rising edge less than 18 ms after the previous accepted strobe is a failure (fail_o=1, irq_n_o=0). The first strobe after reset is exempt from this check.
- R2: If 34 ms pass without a strobe edge after the previous accepted strobe, or after the release of reset, a failure is flagged.
- R3: Strobes spaced 20 to 30 ms apart never cause a failure. In that case irq_n_o stays 1 and fail_o stays 0. A first strobe that arrives within 30 ms of reset never fails.
- R4: After reset, fail_o=0, irq_n_o=1 and armed_o=0. At all times irq_n_o is the inverse of fail_o.
- R5: armed_o starts at 0. Once set it stays 1, and only power-on reset (por_n_i=0) clears it.
- R6: While armed_o=0, the next strobe edge after a failure clears the failure and restarts timing with the window closed.
- R7: While armed_o=1, a failure latches. Later strobes, with or without an arm request, leave fail_o=1 until reset.
- R8: armed_o is set when arm_req_i is 1 during a strobe edge that is accepted (not early, not while locked). An arm request without a strobe does nothing, and an arm request with an early strobe does not arm.
- R9: The strobe is acted on only at its rising edge. Holding strobe_i high counts as a single strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous assert |
| strobe_i | input | 1 | Watchdog strobe from the processor, asynchronous |
| arm_req_i | input | 1 | Arm request, sampled with the strobe edge |
| irq_n_o | output | 1 | Watchdog interrupt, active low |
| fail_o | output | 1 | Failure flag, high blocks amplifier drive |
| armed_o | output | 1 | Arm flag status |

## Verification
The failure outputs are a pure decode of the controller state, so a wrong state transition shows up at the ports on the clock after the offending strobe edge or timeout. An arm flag that is set or dropped wrongly is visible at once on armed_o. It is also visible at the next failure, which then either fails to latch or latches when it should release. A miscounted window moves the edge of a failure into or out of the accepted bands. Spacings well inside and well outside those bands therefore expose a counting fault within one strobe period.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

    typedef enum logic [2:0] {
        WD_BOOT = 3'd0,
        WD_SHUT = 3'd1,
        WD_OPEN = 3'd2,
        WD_TRIP = 3'd3,
        WD_LOCK = 3'd4
    } wd_state_e;

endpackage

// File: rtl/wwdt_sync.sv
module wwdt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_n_i) begin
                    if (!rst_n_i) pipe[0] <= '0;
                    else          pipe[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_n_i) begin
                    if (!rst_n_i) pipe[g] <= '0;
                    else          pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = pipe[STAGES-1];

endmodule

// File: rtl/wwdt_edge.sv
module wwdt_edge (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic level_i,
    output logic rise_o
);

    logic prev_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) prev_q <= 1'b0;
        else          prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/wwdt_tick.sv
module wwdt_tick #(
    parameter int DIV   = 50000,
    parameter int LIMIT = 34,
    parameter int CNT_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             restart_i,
    output logic [CNT_W-1:0] ms_o
);

    localparam int PRE_W = $clog2(DIV + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);
    localparam logic [CNT_W-1:0] MS_SAT   = CNT_W'(LIMIT);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] ms_q;
    logic             tick;

    assign tick = (pre_q == PRE_LAST);

    // Prescaler: one tick per millisecond, re-phased by each accepted strobe
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)       pre_q <= '0;
        else if (restart_i) pre_q <= '0;
        else if (tick)      pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end

    // Elapsed milliseconds, saturating at the late limit
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)                   ms_q <= '0;
        else if (restart_i)             ms_q <= '0;
        else if (tick && ms_q < MS_SAT) ms_q <= ms_q + 1'b1;
    end

    assign ms_o = ms_q;

endmodule

// File: rtl/wwdt_fsm.sv
module wwdt_fsm
    import wwdt_pkg::*;
#(
    parameter int EARLY_MS = 18,
    parameter int LATE_MS  = 34,
    parameter int CNT_W    = 6
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             stb_rise_i,
    input  logic             arm_lvl_i,
    input  logic [CNT_W-1:0] ms_i,
    output logic             restart_o,
    output logic             fail_o,
    output logic             irq_n_o,
    output logic             armed_o
);

    localparam logic [CNT_W-1:0] EARLY_C = CNT_W'(EARLY_MS);
    localparam logic [CNT_W-1:0] LATE_C  = CNT_W'(LATE_MS);

    wd_state_e state_q, state_d;
    logic      armed_q, arm_set;
    wd_state_e fail_dst;

    assign fail_dst = armed_q ? WD_LOCK : WD_TRIP;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        arm_set = 1'b0;
        unique case (state_q)
            WD_BOOT: begin
                if (stb_rise_i) begin
                    state_d = WD_SHUT;            // boot_strobe
                    arm_set = arm_lvl_i;
                end else if (ms_i >= LATE_C) begin
                    state_d = fail_dst;           // timeout
                end
            end
            WD_SHUT: begin
                if (stb_rise_i)              state_d = fail_dst;  // early_strobe
                else if (ms_i >= EARLY_C)    state_d = WD_OPEN;   // window_opens
            end
            WD_OPEN: begin
                if (stb_rise_i) begin
                    state_d = WD_SHUT;            // good_strobe
                    arm_set = arm_lvl_i;
                end else if (ms_i >= LATE_C) begin
                    state_d = fail_dst;           // timeout
                end
            end
            WD_TRIP: begin
                if (stb_rise_i) begin
                    state_d = WD_SHUT;            // release
                    arm_set = arm_lvl_i;
                end
            end
            WD_LOCK: begin
                state_d = WD_LOCK;                // lock_hold
            end
            default: state_d = WD_BOOT;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= WD_BOOT;
        else          state_q <= state_d;
    end

    // Arm flag: set only, cleared by power-on reset
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)     armed_q <= 1'b0;
        else if (arm_set) armed_q <= 1'b1;
    end

    // Outputs decoded from the state register
    always_comb begin
        fail_o    = 1'b0;
        restart_o = stb_rise_i;
        unique case (state_q)
            WD_BOOT, WD_SHUT, WD_OPEN: fail_o = 1'b0;
            WD_TRIP:                   fail_o = 1'b1;
            WD_LOCK: begin
                fail_o    = 1'b1;
                restart_o = 1'b0;
            end
            default:                   fail_o = 1'b1;
        endcase
        irq_n_o = ~fail_o;
        armed_o = armed_q;
    end

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int EARLY_MS    = 18,
    parameter int LATE_MS     = 34,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic strobe_i,
    input  logic arm_req_i,
    output logic irq_n_o,
    output logic fail_o,
    output logic armed_o
);

    localparam int DIV   = (CLK_HZ / 1000 < 2) ? 2 : CLK_HZ / 1000;
    localparam int CNT_W = $clog2(LATE_MS + 1);

    logic [1:0]       sync_lvl;
    logic             stb_rise;
    logic             restart;
    logic [CNT_W-1:0] ms_cnt;

    wwdt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (por_n_i),
        .async_i ({arm_req_i, strobe_i}),
        .sync_o  (sync_lvl)
    );

    wwdt_edge u_edge (
        .clk_i   (clk_i),
        .rst_n_i (por_n_i),
        .level_i (sync_lvl[0]),
        .rise_o  (stb_rise)
    );

    wwdt_tick #(.DIV(DIV), .LIMIT(LATE_MS), .CNT_W(CNT_W)) u_tick (
        .clk_i     (clk_i),
        .rst_n_i   (por_n_i),
        .restart_i (restart),
        .ms_o      (ms_cnt)
    );

    wwdt_fsm #(.EARLY_MS(EARLY_MS), .LATE_MS(LATE_MS), .CNT_W(CNT_W)) u_fsm (
        .clk_i      (clk_i),
        .rst_n_i    (por_n_i),
        .stb_rise_i (stb_rise),
        .arm_lvl_i  (sync_lvl[1]),
        .ms_i       (ms_cnt),
        .restart_o  (restart),
        .fail_o     (fail_o),
        .irq_n_o    (irq_n_o),
        .armed_o    (armed_o)
    );

endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk #(
    parameter int CNT_W   = 6,
    parameter int LATE_MS = 34
) (
    input logic             clk_i,
    input logic             por_n_i,
    input logic             stb_rise,
    input logic [CNT_W-1:0] ms_cnt,
    input logic             fail_o,
    input logic             armed_o
);

    localparam logic [CNT_W-1:0] LATE_C = CNT_W'(LATE_MS);

    AST_ARM_STICKY: assert property (@(posedge clk_i) disable iff (!por_n_i)
        armed_o |=> armed_o); // R5

    AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (fail_o && armed_o) |=> fail_o); // R7

    AST_ARM_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(armed_o) |-> $past(stb_rise)); // R8

    AST_RELEASE_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $fell(fail_o) |-> $past(stb_rise)); // R6

    AST_FAIL_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(fail_o) |-> ($past(stb_rise) || ($past(ms_cnt) >= LATE_C))); // R2

endmodule

bind window_watchdog wwdt_chk #(.CNT_W(CNT_W), .LATE_MS(LATE_MS)) u_chk (
    .clk_i    (clk_i),
    .por_n_i  (por_n_i),
    .stb_rise (stb_rise),
    .ms_cnt   (ms_cnt),
    .fail_o   (fail_o),
    .armed_o  (armed_o)
);

// File: tb/window_watchdog_bench.sv
`timescale 1ns/1ps
module window_watchdog_bench;

    localparam int CLK_HZ = 8000;          // 8 clocks per millisecond tick
    localparam int DIV    = CLK_HZ / 1000;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic strobe = 1'b0;
    logic arm_req = 1'b0;
    logic irq_n, fail, armed;

    int total = 0;
    int bad = 0;
    int since_rise = 0;
    bit done = 1'b0;

    // Reference model state
    bit m_boot, m_fail, m_armed;

    always #10 clk = ~clk;                 // 50 MHz

    window_watchdog #(.CLK_HZ(CLK_HZ)) u_window_watchdog (
        .clk_i     (clk),
        .por_n_i   (por_n),
        .strobe_i  (strobe),
        .arm_req_i (arm_req),
        .irq_n_o   (irq_n),
        .fail_o    (fail),
        .armed_o   (armed)
    );

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            since_rise++;
        end
    endtask

    task automatic check(string req);
        total++;
        if (fail !== m_fail) begin
            bad++;
            $display("FAIL %s fail_o actual=%b expected=%b", req, fail, m_fail);
        end
        total++;
        if (irq_n !== !m_fail) begin
            bad++;
            $display("FAIL %s irq_n_o actual=%b expected=%b", req, irq_n, !m_fail);
        end
        total++;
        if (armed !== m_armed) begin
            bad++;
            $display("FAIL %s armed_o actual=%b expected=%b", req, armed, m_armed);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        por_n = 1'b0;
        strobe = 1'b0;
        arm_req = 1'b0;
        tick(5);
        por_n = 1'b1;
        since_rise = 0;
        m_boot = 1'b1; m_fail = 1'b0; m_armed = 1'b0;
        tick(2);
        check("R4");      // reset state; R5 arm flag starts clear
    endtask

    function automatic bit is_early(int gap_ms);
        return !m_boot && gap_ms < 18;
    endfunction

    // One strobe gap_ms after the previous rising edge, held hold_cyc cycles
    task automatic strobe_event(int gap_ms, bit arm, int hold_cyc);
        string tag;
        int pre;
        pre = gap_ms * DIV - 4 - since_rise;
        if (pre > 0) tick(pre);
        if (!m_fail && gap_ms >= 36) begin
            m_fail = 1'b1;
            tag = "R2";
        end else if (m_fail && m_armed) tag = "R7";
        else tag = "R3";
        check(tag);
        tick(4);
        strobe = 1'b1;
        arm_req = arm;
        since_rise = 0;
        tick(hold_cyc < 3 ? 3 : hold_cyc);
        strobe = 1'b0;
        arm_req = 1'b0;
        tick(2);
        if (m_fail) begin
            if (m_armed) tag = "R7";
            else begin
                m_fail = 1'b0; m_boot = 1'b0;
                if (arm) m_armed = 1'b1;
                tag = "R6";
            end
        end else if (is_early(gap_ms)) begin
            m_fail = 1'b1;
            tag = arm ? "R8" : "R1";
        end else begin
            m_boot = 1'b0;
            if (arm) m_armed = 1'b1;
            tag = (hold_cyc > 3) ? "R9" : (arm ? "R8" : "R3");
        end
        check(tag);
    endtask

    function automatic int pick_gap(int cls);
        if (cls < 3)      return 2 + int'($urandom % 16);   // 2..17
        else if (cls < 8) return 20 + int'($urandom % 11);  // 20..30
        else              return 36 + int'($urandom % 10);  // 36..45
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        m_boot = 1'b1; m_fail = 1'b0; m_armed = 1'b0;

        // Directed: start-up self test
        do_reset();
        strobe_event(10, 1'b0, 3);     // R3 first strobe exempt
        strobe_event(10, 1'b0, 3);     // R1 early
        strobe_event(25, 1'b0, 3);     // R6 release
        strobe_event(40, 1'b0, 3);     // R2 late, then R6 release
        strobe_event(25, 1'b0, 3);     // R3
        strobe_event(22, 1'b0, 12 * DIV); // R9 long high level counts once
        strobe_event(25, 1'b0, 3);     // R9 next edge still in window
        // R8 arm request alone does nothing
        arm_req = 1'b1;
        tick(6);
        arm_req = 1'b0;
        tick(3);
        check("R8");
        strobe_event(8, 1'b1, 3);      // R8 early strobe does not arm
        strobe_event(25, 1'b0, 3);     // R6 release
        strobe_event(25, 1'b1, 3);     // R8 arm on good strobe
        strobe_event(25, 1'b0, 3);     // R5 stays armed
        strobe_event(50, 1'b0, 3);     // R2 late then R7 latched
        strobe_event(25, 1'b0, 3);     // R7 ignored
        strobe_event(25, 1'b1, 3);     // R7 ignored
        do_reset();                    // R5 cleared by reset

        // Armed early failure latches
        strobe_event(20, 1'b1, 3);
        strobe_event(12, 1'b0, 3);     // R1 then latched
        strobe_event(25, 1'b0, 3);     // R7

        // Boot timeout with no strobe at all
        do_reset();
        strobe_event(40, 1'b0, 3);     // R2 then R6

        // Random episodes
        for (int ep = 0; ep < 6; ep++) begin
            do_reset();
            for (int i = 0; i < 14; i++) begin
                int cls;
                cls = int'($urandom % 10);
                strobe_event(pick_gap(cls), ($urandom % 5) == 0, 3);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule